// File: doc/BRIEF.md
# DDR SDRAM Bank State Tracker and Command Legality Checker

This block sits beside the command bus of a multi-bank double-data-rate SDRAM. It follows every decoded command and keeps a state for each bank. A bank can be idle, opening a row, holding an open row, bursting a read or a write, bursting with automatic close, or closing its row. The block also keeps a device-wide mode for the operations that stall the whole device: refresh, mode-register load and close-all.

Each command is judged against the current state of its target bank, or of all banks when the command is device-wide. An illegal command raises a one-cycle error pulse and changes no state. A legal command moves the bank or device into its next state. Every transient state lasts for a parameterised number of clock cycles and then ends by itself. No data path, strobe capture or electrical timing is modelled.

The block is meant for checking a memory controller in simulation or on silicon. Its per-bank outputs can also act as a scoreboard for a scheduler.

Top module: `ddr_bank_monitor`

## Requirements
- R1: After reset every bank reads state 0 (idle), the device mode reads 0 (normal) and the error output is low.
- R2: Command 2 (open row) to an idle bank puts that bank in state 1 (opening) for exactly T_RCD cycles and then state 2 (row open). Every command other than 0 or 1 aimed at an opening bank is illegal.
- R3: Command 3 (read) or 4 (write) with the auto-close bit low is legal in states 2, 3 and 4. It puts the bank in state 3 (reading) or 4 (writing) for BURST_LEN/2 cycles, and the bank then returns to state 2.
- R4: A read or write with the auto-close bit high puts the bank in state 5 (read, auto-close) or 6 (write, auto-close) for BURST_LEN/2 cycles. The bank then enters state 7 (closing) for T_RP cycles and ends in state 0. Every command other than 0 or 1 to that bank is illegal throughout this sequence.
- R5: Command 5 (close bank) is legal in states 0, 2, 3 and 4. From states 2, 3 or 4 it gives state 7 for T_RP cycles and then state 0. From state 0 it changes nothing. It is illegal in states 1, 5, 6 and 7.
- R6: Command 7 (refresh) and command 8 (mode load) are legal only when every bank is in state 0. They set the device mode to 1 for T_RFC cycles or to 2 for T_MRD cycles, and the mode then returns to 0.
- R7: Command 6 (close all) is legal only when every bank is in state 0, 2, 3 or 4. It sets the device mode to 3 for T_RP cycles, and each bank that is not idle goes to state 7 for T_RP cycles.
- R8: While the device mode is not 0, only commands 0 (no-op) and 1 (deselect) are legal.
- R9: Command 9 (burst stop) ignores the bank address. It is legal only when the bank that received the most recent legal read is in state 3, and it returns that bank to state 2.
- R10: A command that is illegal, including any reserved code from 10 to 15, drives the error output high for the one cycle after the edge that sampled it, and leaves all bank states and the device mode as they would be with a no-op.
- R11: A command to one bank is judged only against that bank's state, so it stays legal while another bank is in a transient state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_i | input | 4 | Decoded command code |
| ba_i | input | $clog2(NUM_BANKS) | Target bank address |
| ap_i | input | 1 | Auto-close bit for read and write |
| bank_state_o | output | 3*NUM_BANKS | Per-bank state codes, bank b in bits [3b+2:3b] |
| dev_mode_o | output | 2 | Device-wide mode; nonzero means busy |
| cmd_err_o | output | 1 | One-cycle pulse for an illegal command |

## Verification
The bench drives command sequences and compares every output on every clock against a behavioural model. Back-to-back commands to a bank that is still opening or closing are separated from commands to other banks; this shows whether the legality lookup is really per bank. Bursts are stopped, interrupted by new bursts and left to expire with and without auto-close; this distinguishes the stop pointer, the override of a running countdown and the hand-off from burst to close. Device-wide commands are issued both with banks open and with all banks idle, and are followed by commands during the busy window; this exercises the all-bank preconditions and the no-op-only lockout.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;

   localparam logic [3:0] C_NOP   = 4'd0;
   localparam logic [3:0] C_DESEL = 4'd1;
   localparam logic [3:0] C_OPEN  = 4'd2;
   localparam logic [3:0] C_RD    = 4'd3;
   localparam logic [3:0] C_WR    = 4'd4;
   localparam logic [3:0] C_CLOSE = 4'd5;
   localparam logic [3:0] C_CLALL = 4'd6;
   localparam logic [3:0] C_REF   = 4'd7;
   localparam logic [3:0] C_MODE  = 4'd8;
   localparam logic [3:0] C_STOP  = 4'd9;

   typedef enum logic [2:0] {
      BS_IDLE    = 3'd0,
      BS_OPENING = 3'd1,
      BS_OPEN    = 3'd2,
      BS_READ    = 3'd3,
      BS_WRITE   = 3'd4,
      BS_RD_AC   = 3'd5,
      BS_WR_AC   = 3'd6,
      BS_CLOSING = 3'd7
   } bank_st_e;

   typedef enum logic [1:0] {
      DM_NORMAL  = 2'd0,
      DM_REFRESH = 2'd1,
      DM_MODELD  = 2'd2,
      DM_CLALL   = 2'd3
   } dev_mode_e;

endpackage

// File: rtl/ddr_bank_track.sv
module ddr_bank_track
   import ddr_mon_pkg::*;
#(
   parameter int T_RCD     = 3,
   parameter int T_RP      = 3,
   parameter int BURST_CYC = 2,
   parameter int CNT_W     = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go_i,
   input  logic [3:0] cmd_i,
   input  logic       ap_i,
   output logic [2:0] st_o
);

   localparam logic [CNT_W-1:0] RCD_LD = CNT_W'(T_RCD - 1);
   localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(T_RP - 1);
   localparam logic [CNT_W-1:0] BST_LD = CNT_W'(BURST_CYC - 1);

   bank_st_e         st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             cnt_zero;

   assign cnt_zero = (cnt_q == '0);
   assign st_o     = st_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= BS_IDLE;
         cnt_q <= '0;
      end else if (go_i) begin
         unique case (cmd_i)
            C_OPEN: begin
               st_q  <= BS_OPENING;
               cnt_q <= RCD_LD;
            end
            C_RD: begin
               st_q  <= ap_i ? BS_RD_AC : BS_READ;
               cnt_q <= BST_LD;
            end
            C_WR: begin
               st_q  <= ap_i ? BS_WR_AC : BS_WRITE;
               cnt_q <= BST_LD;
            end
            C_CLOSE, C_CLALL: begin
               if (st_q != BS_IDLE) begin
                  st_q  <= BS_CLOSING;
                  cnt_q <= RP_LD;
               end
            end
            C_STOP: begin
               st_q  <= BS_OPEN;
               cnt_q <= '0;
            end
            default: ;
         endcase
      end else begin
         unique case (st_q)
            BS_OPENING, BS_READ, BS_WRITE: begin
               if (cnt_zero) st_q <= BS_OPEN;
               else          cnt_q <= cnt_q - 1'b1;
            end
            BS_RD_AC, BS_WR_AC: begin
               if (cnt_zero) begin
                  st_q  <= BS_CLOSING;
                  cnt_q <= RP_LD;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            BS_CLOSING: begin
               if (cnt_zero) st_q <= BS_IDLE;
               else          cnt_q <= cnt_q - 1'b1;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/ddr_dev_timer.sv
module ddr_dev_timer
   import ddr_mon_pkg::*;
#(
   parameter int T_RFC = 8,
   parameter int T_MRD = 2,
   parameter int T_RP  = 3,
   parameter int CNT_W = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic [3:0] cmd_i,
   output logic [1:0] mode_o
);

   localparam logic [CNT_W-1:0] RFC_LD = CNT_W'(T_RFC - 1);
   localparam logic [CNT_W-1:0] MRD_LD = CNT_W'(T_MRD - 1);
   localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(T_RP - 1);

   dev_mode_e        mode_q;
   logic [CNT_W-1:0] cnt_q;

   assign mode_o = mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= DM_NORMAL;
         cnt_q  <= '0;
      end else if (start_i) begin
         unique case (cmd_i)
            C_REF: begin
               mode_q <= DM_REFRESH;
               cnt_q  <= RFC_LD;
            end
            C_MODE: begin
               mode_q <= DM_MODELD;
               cnt_q  <= MRD_LD;
            end
            C_CLALL: begin
               mode_q <= DM_CLALL;
               cnt_q  <= RP_LD;
            end
            default: ;
         endcase
      end else if (mode_q != DM_NORMAL) begin
         if (cnt_q == '0) mode_q <= DM_NORMAL;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/ddr_cmd_judge.sv
module ddr_cmd_judge
   import ddr_mon_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int BANK_W    = 2
) (
   input  logic [NUM_BANKS-1:0][2:0] st_i,
   input  logic [1:0]                mode_i,
   input  logic [3:0]                cmd_i,
   input  logic [BANK_W-1:0]         ba_i,
   input  logic [BANK_W-1:0]         last_rd_i,
   output logic                      legal_o,
   output logic [NUM_BANKS-1:0]      go_o,
   output logic                      dev_start_o
);

   logic [NUM_BANKS-1:0] is_idle;
   logic [NUM_BANKS-1:0] can_close;
   logic [2:0]           tgt_st;
   logic [2:0]           rd_st;
   logic                 all_idle;
   logic                 all_closable;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_flags
      assign is_idle[b]   = (st_i[b] == BS_IDLE);
      assign can_close[b] = (st_i[b] == BS_IDLE) || (st_i[b] == BS_OPEN) ||
                            (st_i[b] == BS_READ) || (st_i[b] == BS_WRITE);
   end

   assign all_idle     = &is_idle;
   assign all_closable = &can_close;
   assign tgt_st       = st_i[ba_i];
   assign rd_st        = st_i[last_rd_i];

   always_comb begin
      legal_o = 1'b0;
      if (cmd_i == C_NOP || cmd_i == C_DESEL) begin
         legal_o = 1'b1;
      end else if (mode_i == DM_NORMAL) begin
         unique case (cmd_i)
            C_OPEN:        legal_o = (tgt_st == BS_IDLE);
            C_RD, C_WR:    legal_o = (tgt_st == BS_OPEN) || (tgt_st == BS_READ) ||
                                     (tgt_st == BS_WRITE);
            C_CLOSE:       legal_o = can_close[ba_i];
            C_CLALL:       legal_o = all_closable;
            C_REF, C_MODE: legal_o = all_idle;
            C_STOP:        legal_o = (rd_st == BS_READ);
            default:       legal_o = 1'b0;
         endcase
      end
   end

   always_comb begin
      for (int b = 0; b < NUM_BANKS; b++) begin
         unique case (cmd_i)
            C_OPEN, C_RD, C_WR, C_CLOSE: go_o[b] = legal_o && (ba_i == BANK_W'(b));
            C_CLALL:                     go_o[b] = legal_o;
            C_STOP:                      go_o[b] = legal_o && (last_rd_i == BANK_W'(b));
            default:                     go_o[b] = 1'b0;
         endcase
      end
   end

   assign dev_start_o = legal_o &&
                        (cmd_i == C_REF || cmd_i == C_MODE || cmd_i == C_CLALL);

endmodule

// File: rtl/ddr_bank_monitor.sv
module ddr_bank_monitor
   import ddr_mon_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int T_RCD     = 3,
   parameter int T_RP      = 3,
   parameter int T_RFC     = 8,
   parameter int T_MRD     = 2,
   parameter int BURST_LEN = 4,
   localparam int BANK_W   = $clog2(NUM_BANKS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [3:0]             cmd_i,
   input  logic [BANK_W-1:0]      ba_i,
   input  logic                   ap_i,
   output logic [3*NUM_BANKS-1:0] bank_state_o,
   output logic [1:0]             dev_mode_o,
   output logic                   cmd_err_o
);

   localparam int BURST_CYC = BURST_LEN / 2;
   localparam int MAX_AB    = (T_RCD > T_RP) ? T_RCD : T_RP;
   localparam int MAX_CD    = (T_RFC > T_MRD) ? T_RFC : T_MRD;
   localparam int MAX_ABCD  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
   localparam int MAX_T     = (MAX_ABCD > BURST_CYC) ? MAX_ABCD : BURST_CYC;
   localparam int CNT_W     = $clog2(MAX_T + 1);

   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two, at least 2");
   end
   if (T_RCD < 1 || T_RP < 1 || T_RFC < 1 || T_MRD < 1) begin : g_bad_timing
      $error("all timing parameters must be at least one cycle");
   end
   if (BURST_LEN < 2 || (BURST_LEN % 2) != 0) begin : g_bad_burst
      $error("BURST_LEN must be even and at least 2");
   end

   logic [NUM_BANKS-1:0][2:0] st;
   logic [NUM_BANKS-1:0]      go;
   logic [1:0]                mode;
   logic                      legal;
   logic                      dev_start;
   logic [BANK_W-1:0]         last_rd_q;
   logic                      err_q;

   ddr_cmd_judge #(
      .NUM_BANKS (NUM_BANKS),
      .BANK_W    (BANK_W)
   ) u_judge (
      .st_i        (st),
      .mode_i      (mode),
      .cmd_i       (cmd_i),
      .ba_i        (ba_i),
      .last_rd_i   (last_rd_q),
      .legal_o     (legal),
      .go_o        (go),
      .dev_start_o (dev_start)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      ddr_bank_track #(
         .T_RCD     (T_RCD),
         .T_RP      (T_RP),
         .BURST_CYC (BURST_CYC),
         .CNT_W     (CNT_W)
      ) u_bank (
         .clk   (clk),
         .rst_n (rst_n),
         .go_i  (go[b]),
         .cmd_i (cmd_i),
         .ap_i  (ap_i),
         .st_o  (st[b])
      );
   end

   ddr_dev_timer #(
      .T_RFC (T_RFC),
      .T_MRD (T_MRD),
      .T_RP  (T_RP),
      .CNT_W (CNT_W)
   ) u_dev (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (dev_start),
      .cmd_i   (cmd_i),
      .mode_o  (mode)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_rd_q <= '0;
         err_q     <= 1'b0;
      end else begin
         err_q <= !legal;
         if (legal && cmd_i == C_RD) last_rd_q <= ba_i;
      end
   end

   assign bank_state_o = st;
   assign dev_mode_o   = mode;
   assign cmd_err_o    = err_q;

endmodule

// File: rtl/ddr_bank_monitor_chk.sv
module ddr_bank_monitor_chk
   import ddr_mon_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   localparam int BANK_W   = $clog2(NUM_BANKS)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [3:0]             cmd_i,
   input logic [BANK_W-1:0]      ba_i,
   input logic [3*NUM_BANKS-1:0] bank_state_o,
   input logic [1:0]             dev_mode_o,
   input logic                   cmd_err_o
);

   logic [2:0]        st [NUM_BANKS];
   logic [BANK_W-1:0] ba_q;
   logic              all_idle;

   always_comb begin
      all_idle = 1'b1;
      for (int b = 0; b < NUM_BANKS; b++) begin
         st[b] = bank_state_o[3*b +: 3];
         if (st[b] != BS_IDLE) all_idle = 1'b0;
      end
   end

   always_ff @(posedge clk) ba_q <= ba_i;

   p_reserved_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i > C_STOP) |=> cmd_err_o);

   p_busy_only_nop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_mode_o != DM_NORMAL && cmd_i > C_DESEL) |=> cmd_err_o);

   p_ref_needs_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == C_REF && !all_idle) |=> cmd_err_o);

   p_ref_enter_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == C_REF && all_idle && dev_mode_o == DM_NORMAL)
      |=> (dev_mode_o == DM_REFRESH && !cmd_err_o));

   p_open_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == C_OPEN && st[ba_i] == BS_IDLE && dev_mode_o == DM_NORMAL)
      |=> (st[ba_q] == BS_OPENING));

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_props
      p_closing_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (st[b] == BS_CLOSING) |=> (st[b] == BS_CLOSING || st[b] == BS_IDLE));

      p_opening_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (st[b] == BS_OPENING) |=> (st[b] == BS_OPENING || st[b] == BS_OPEN));
   end

endmodule

bind ddr_bank_monitor ddr_bank_monitor_chk #(
   .NUM_BANKS (NUM_BANKS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_i        (cmd_i),
   .ba_i         (ba_i),
   .bank_state_o (bank_state_o),
   .dev_mode_o   (dev_mode_o),
   .cmd_err_o    (cmd_err_o)
);

// File: tb/ddr_bank_monitor_bench.sv
`timescale 1ns/100ps
module ddr_bank_monitor_bench;

   localparam int NB  = 4;
   localparam int RCD = 3;
   localparam int RP  = 3;
   localparam int RFC = 8;
   localparam int MRD = 2;
   localparam int BL  = 4;
   localparam int BC  = BL / 2;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [3:0]    cmd;
   logic [1:0]    ba;
   logic          ap;
   logic [3*NB-1:0] bank_state;
   logic [1:0]    dev_mode;
   logic          cmd_err;

   int checks = 0;
   int errors = 0;
   string req = "R1";
   bit done = 1'b0;

   int m_st [NB];
   int m_rem [NB];
   int m_mode, m_drem, m_last;
   bit m_err;

   always #2.5 clk = ~clk;

   ddr_bank_monitor #(
      .NUM_BANKS (NB), .T_RCD (RCD), .T_RP (RP),
      .T_RFC (RFC), .T_MRD (MRD), .BURST_LEN (BL)
   ) u_ddr_bank_monitor (
      .clk (clk), .rst_n (rst_n), .cmd_i (cmd), .ba_i (ba), .ap_i (ap),
      .bank_state_o (bank_state), .dev_mode_o (dev_mode), .cmd_err_o (cmd_err)
   );

   function automatic bit closable(int s);
      return (s == 0 || s == 2 || s == 3 || s == 4);
   endfunction

   function automatic bit m_legal(int c, int b);
      bit ok;
      if (c == 0 || c == 1) return 1'b1;
      if (m_mode != 0) return 1'b0;
      case (c)
         2: return m_st[b] == 0;
         3, 4: return m_st[b] == 2 || m_st[b] == 3 || m_st[b] == 4;
         5: return closable(m_st[b]);
         6: begin
            ok = 1'b1;
            foreach (m_st[i]) if (!closable(m_st[i])) ok = 1'b0;
            return ok;
         end
         7, 8: begin
            ok = 1'b1;
            foreach (m_st[i]) if (m_st[i] != 0) ok = 1'b0;
            return ok;
         end
         9: return m_st[m_last] == 3;
         default: return 1'b0;
      endcase
   endfunction

   task automatic m_advance(int c, int b, bit a, bit lg);
      for (int i = 0; i < NB; i++) begin
         if (m_st[i] != 0 && m_st[i] != 2) begin
            m_rem[i]--;
            if (m_rem[i] == 0) begin
               if (m_st[i] == 5 || m_st[i] == 6) begin
                  m_st[i] = 7; m_rem[i] = RP;
               end else if (m_st[i] == 7) m_st[i] = 0;
               else m_st[i] = 2;
            end
         end
      end
      if (m_mode != 0) begin
         m_drem--;
         if (m_drem == 0) m_mode = 0;
      end
      m_err = !lg;
      if (!lg) return;
      case (c)
         2: begin m_st[b] = 1; m_rem[b] = RCD; end
         3: begin m_st[b] = a ? 5 : 3; m_rem[b] = BC; m_last = b; end
         4: begin m_st[b] = a ? 6 : 4; m_rem[b] = BC; end
         5: if (m_st[b] != 0) begin m_st[b] = 7; m_rem[b] = RP; end
         6: begin
            for (int i = 0; i < NB; i++)
               if (m_st[i] != 0) begin m_st[i] = 7; m_rem[i] = RP; end
            m_mode = 3; m_drem = RP;
         end
         7: begin m_mode = 1; m_drem = RFC; end
         8: begin m_mode = 2; m_drem = MRD; end
         9: m_st[m_last] = 2;
         default: ;
      endcase
   endtask

   task automatic compare();
      for (int i = 0; i < NB; i++) begin
         checks++;
         if (int'(bank_state[3*i +: 3]) != m_st[i]) begin
            errors++;
            $display("FAIL %s bank%0d state actual=%0d expected=%0d",
                     req, i, bank_state[3*i +: 3], m_st[i]);
         end
      end
      checks++;
      if (int'(dev_mode) != m_mode) begin
         errors++;
         $display("FAIL %s dev_mode actual=%0d expected=%0d", req, dev_mode, m_mode);
      end
      checks++;
      if (cmd_err != m_err) begin
         errors++;
         $display("FAIL %s cmd_err actual=%0b expected=%0b", req, cmd_err, m_err);
      end
   endtask

   task automatic step(int c, int b = 0, bit a = 1'b0);
      bit lg;
      @(negedge clk);
      cmd = 4'(c); ba = 2'(b); ap = a;
      lg = m_legal(c, b);
      @(posedge clk);
      m_advance(c, b, a, lg);
      #1;
      compare();
   endtask

   task automatic nop(int n);
      for (int k = 0; k < n; k++) step(0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired in %s", req);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      foreach (m_st[i]) begin m_st[i] = 0; m_rem[i] = 0; end
      m_mode = 0; m_drem = 0; m_last = 0; m_err = 1'b0;
      rst_n = 1'b0; cmd = 4'd0; ba = 2'd0; ap = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      req = "R1"; compare();
      @(negedge clk); rst_n = 1'b1;

      req = "R2";  step(2, 0); step(3, 0); step(5, 0);
      req = "R11"; step(2, 1); nop(3);
      req = "R3";  step(3, 0); nop(1); step(4, 0); step(3, 1); nop(3);
      req = "R9";  step(3, 1); step(9, 3); nop(3); step(9, 0);
      step(4, 0); step(9, 0); nop(3);
      req = "R5";  step(5, 0); step(5, 0); step(2, 0); nop(3); step(5, 2);
      req = "R6";  step(7); step(8);
      req = "R7";  step(6);
      req = "R8";  step(2, 2); step(7); step(15, 1); nop(3);
      req = "R6";  step(7);
      req = "R8";  step(8); step(5, 0);
      nop(8);
      req = "R6";  step(8); nop(2);
      req = "R4";  step(2, 2); nop(3); step(3, 2, 1'b1); step(3, 2); step(5, 2);
      req = "R11"; step(2, 3);
      req = "R4";  nop(2); step(5, 2); step(2, 2); nop(3);
      step(4, 3, 1'b1);
      req = "R7";  step(6); nop(6);
      req = "R10"; step(12, 0); step(15, 1); step(10, 3);
      req = "R5";  step(2, 0); nop(3); step(3, 0); step(5, 0); nop(4);
      req = "R7";  step(2, 1); nop(3); step(6); step(2, 1); nop(4);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule